// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block carries out the sixteen data-processing operations of a 32-bit RISC integer core: logic operations, moves and bit-clear, plain and carry-chained additions and subtractions in both operand orders, and four comparison forms that only update the flags. Each cycle with `in_valid` high it takes the first operand, the shifter operand, the shifter's carry-out, the current flags and an opcode. One clock edge later it presents the result, a destination write enable, the next flag value and an unsupported-encoding indication.

All arithmetic goes through one 33-bit adder. Its operands are steered, and optionally inverted, according to the opcode, and its carry-in is chosen to match. The block also resolves the case where the first operand is the program counter, using the instruction address plus the pipeline offset.

Top module: `alu_dp`

## Requirements
- R1: Logic opcodes produce: 0 = a AND b, 1 = a XOR b, 12 = a OR b, 13 = b, 14 = a AND NOT b, 15 = NOT b (a is the first operand, b the shifter operand; opcode is the 4-bit `opcode` input).
- R2: Opcode 2 yields a − b, opcode 3 yields b − a and opcode 4 yields a + b. For 2 and 3 the carry-in of the adder is forced to 1, and for 4 it is forced to 0.
- R3: Opcodes 5 (a + b + C), 6 (a + NOT b + C) and 7 (b + NOT a + C) take the stored C flag (`flags_in[1]`) as their adder carry-in.
- R4: Opcodes 8 to 11 (test-AND, test-XOR, compare, compare-negative) never assert `reg_we`. All other opcodes assert it for a valid operation.
- R5: Opcodes 8 to 11 with `set_flags` low are flagged by `unsupported` = 1, and their flags stay unchanged.
- R6: With `set_flags` high, N (`flags_out[3]`) equals result bit 31 and Z (`flags_out[2]`) is 1 exactly when the result is zero. The flag order is {N,Z,C,V}.
- R7: For arithmetic opcodes with `set_flags` high, C is the adder's carry-out. For subtractions this is 1 when no borrow occurs.
- R8: For arithmetic opcodes with `set_flags` high, V is set when the adder inputs share a sign and the sum's sign differs. For a subtraction this means the operands differ in sign and the result's sign matches the subtrahend.
- R9: For logic opcodes with `set_flags` high, C takes `shift_carry` and V keeps its previous value.
- R10: With `set_flags` low, `flags_out` equals `flags_in`.
- R11: When `a_is_pc` is 1, the first operand is `inst_addr` + 8, or `inst_addr` + 12 when `reg_shift` is 1. When `a_is_pc` is 0, `op_a` is used and `inst_addr` has no effect.
- R12: Outputs appear one cycle after `in_valid`. When `rst_n` is low at a clock edge, every output is cleared to 0. A cycle without `in_valid` gives `out_valid`, `reg_we` and `unsupported` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| opcode | input | 4 | Data-processing opcode |
| set_flags | input | 1 | Update condition flags |
| op_a | input | 32 | First operand register value |
| a_is_pc | input | 1 | First operand is the program counter |
| inst_addr | input | 32 | Address of the executing instruction |
| reg_shift | input | 1 | Shift amount comes from a register |
| op_b | input | 32 | Shifter operand |
| shift_carry | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Operation result |
| reg_we | output | 1 | Destination write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| unsupported | output | 1 | Encoding not handled |

## Verification
Two things happen in the same cycle for a compare or test opcode with flags enabled: the flag update (R6 to R9) and the suppression of the destination write (R4). Vectors for opcodes 8 to 11 therefore check `reg_we` and `flags_out` together. The arithmetic cases are chosen so that carry, overflow and zero are each provoked, for example a compare of equal values and a compare whose result overflows. The unsupported case is judged in the same way, with the hold of the flags (R10) checked alongside the `unsupported` indication (R5).

// File: rtl/alu_dp_pkg.sv
// Shared opcode encoding and classification helpers for the data-processing ALU.
package alu_dp_pkg;

    localparam int DW = 32;
    localparam int FW = 4;   // {N,Z,C,V}

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    // True for the flag-only opcodes that never write the destination.
    function automatic logic is_test_op(input logic [3:0] op);
        return op[3:2] == 2'b10;
    endfunction

    // True for opcodes whose C and V come from the adder.
    function automatic logic is_arith_op(input logic [3:0] op);
        return (op >= 4'd2 && op <= 4'd7) || op == 4'd10 || op == 4'd11;
    endfunction

endpackage

// File: rtl/alu_dp_opsel.sv
// First-operand select: substitutes the pipelined program-counter value when
// the source register is the PC. Assumes the PC reads two words ahead, or three
// when the shift amount is register-specified.
module alu_dp_opsel #(
    parameter int DW       = 32,
    parameter int PC_AHEAD = 8,
    parameter int PC_EXTRA = 4
) (
    input  logic [DW-1:0] op_a,
    input  logic          a_is_pc,
    input  logic [DW-1:0] inst_addr,
    input  logic          reg_shift,
    output logic [DW-1:0] a_eff
);
    localparam logic [DW-1:0] OFS_IMM = DW'(PC_AHEAD);
    localparam logic [DW-1:0] OFS_REG = DW'(PC_AHEAD + PC_EXTRA);

    // Pick register value or PC plus its pipeline offset.
    always_comb begin
        if (a_is_pc) a_eff = inst_addr + (reg_shift ? OFS_REG : OFS_IMM);
        else         a_eff = op_a;
    end
endmodule

// File: rtl/alu_dp_core.sv
// Combinational operation core: logic unit, one carry-in adder with operand
// steering, and the flag generator. Assumes flags are ordered {N,Z,C,V}.
module alu_dp_core
    import alu_dp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    opcode,
    input  logic          set_flags,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          shift_carry,
    input  logic [3:0]    flags_in,
    output logic [DW-1:0] res,
    output logic          we,
    output logic [3:0]    flags_nx,
    output logic          unsup
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] add_x, add_y, logic_res;
    logic          add_cin;
    logic [DW:0]   sum;
    logic          arith, test_op, v_add;

    assign arith   = is_arith_op(opcode);
    assign test_op = is_test_op(opcode);

    // Steer adder inputs and carry-in per opcode.
    always_comb begin
        add_x   = a;
        add_y   = b;
        add_cin = 1'b0;
        unique case (dp_op_e'(opcode))
            OP_SUB, OP_CMP: begin add_y = ~b; add_cin = 1'b1; end
            OP_RSB:         begin add_x = b; add_y = ~a; add_cin = 1'b1; end
            OP_ADC:         add_cin = flags_in[1];
            OP_SBC:         begin add_y = ~b; add_cin = flags_in[1]; end
            OP_RSC:         begin add_x = b; add_y = ~a; add_cin = flags_in[1]; end
            default:        add_cin = 1'b0;
        endcase
    end

    assign sum   = {1'b0, add_x} + {1'b0, add_y} + {{DW{1'b0}}, add_cin};
    assign v_add = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);

    // Bitwise and move results.
    always_comb begin
        unique case (dp_op_e'(opcode))
            OP_AND, OP_TST: logic_res = a & b;
            OP_XOR, OP_TEQ: logic_res = a ^ b;
            OP_ORR:         logic_res = a | b;
            OP_MOV:         logic_res = b;
            OP_BIC:         logic_res = a & ~b;
            OP_MVN:         logic_res = ~b;
            default:        logic_res = '0;
        endcase
    end

    assign res   = arith ? sum[DW-1:0] : logic_res;
    assign we    = !test_op;
    assign unsup = test_op && !set_flags;

    // Next flags: hold unless flags are set by a supported encoding.
    always_comb begin
        if (!set_flags) begin
            flags_nx = flags_in;
        end else begin
            flags_nx[3] = res[MSB];
            flags_nx[2] = (res == '0);
            flags_nx[1] = arith ? sum[DW] : shift_carry;
            flags_nx[0] = arith ? v_add   : flags_in[0];
        end
    end
endmodule

// File: rtl/alu_dp.sv
// Top of the data-processing ALU: selects the first operand, runs the core and
// registers all outputs one cycle after a valid request. Synchronous reset.
module alu_dp
    import alu_dp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    opcode,
    input  logic          set_flags,
    input  logic [DW-1:0] op_a,
    input  logic          a_is_pc,
    input  logic [DW-1:0] inst_addr,
    input  logic          reg_shift,
    input  logic [DW-1:0] op_b,
    input  logic          shift_carry,
    input  logic [3:0]    flags_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          reg_we,
    output logic [3:0]    flags_out,
    output logic          unsupported
);
    logic [DW-1:0] a_eff, c_res;
    logic          c_we, c_unsup;
    logic [3:0]    c_flags;

    alu_dp_opsel #(.DW(DW)) u_opsel (
        .op_a(op_a), .a_is_pc(a_is_pc), .inst_addr(inst_addr),
        .reg_shift(reg_shift), .a_eff(a_eff)
    );

    alu_dp_core #(.DW(DW)) u_core (
        .opcode(opcode), .set_flags(set_flags), .a(a_eff), .b(op_b),
        .shift_carry(shift_carry), .flags_in(flags_in),
        .res(c_res), .we(c_we), .flags_nx(c_flags), .unsup(c_unsup)
    );

    // Output register stage; result and flags hold while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            reg_we      <= 1'b0;
            flags_out   <= '0;
            unsupported <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            reg_we      <= in_valid && c_we;
            unsupported <= in_valid && c_unsup;
            if (in_valid) begin
                result    <= c_res;
                flags_out <= c_flags;
            end
        end
    end

    a_r4_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(opcode[3:2] == 2'b10) |-> !reg_we);

    a_r5_unsup_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> out_valid && !reg_we);

    a_r6_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(set_flags) |-> flags_out[3] == result[DW-1]);

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(set_flags) |-> flags_out[2] == (result == '0));

    a_r9_logic_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(set_flags) && !$past(is_arith_op(opcode))
        |-> flags_out[0] == $past(flags_in[0]));

    a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !$past(set_flags) |-> flags_out == $past(flags_in));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !reg_we && !unsupported);
endmodule

// File: tb/alu_dp_bench.sv
module alu_dp_bench;
    typedef struct packed {
        logic [3:0]  op;
        logic        s;
        logic [31:0] a;
        logic [31:0] b;
        logic        sc;
        logic [3:0]  fin;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;
        logic        un;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{4'd0,  1'b1, 32'hF0F0_0000, 32'hFF00_00FF, 1'b1, 4'b0001, 32'hF000_0000, 1'b1, 4'b1011, 1'b0}, // R1 R9
        '{4'd1,  1'b0, 32'h1234_5678, 32'h1234_5678, 1'b0, 4'b1010, 32'h0000_0000, 1'b1, 4'b1010, 1'b0}, // R1 R10
        '{4'd2,  1'b1, 32'd5,         32'd7,         1'b0, 4'b0000, 32'hFFFF_FFFE, 1'b1, 4'b1000, 1'b0}, // R2 R7
        '{4'd3,  1'b1, 32'd1,         32'd0,         1'b0, 4'b0000, 32'hFFFF_FFFF, 1'b1, 4'b1000, 1'b0}, // R2
        '{4'd4,  1'b1, 32'h7FFF_FFFF, 32'd1,         1'b0, 4'b0000, 32'h8000_0000, 1'b1, 4'b1001, 1'b0}, // R2 R8
        '{4'd5,  1'b1, 32'hFFFF_FFFF, 32'd0,         1'b0, 4'b0010, 32'h0000_0000, 1'b1, 4'b0110, 1'b0}, // R3
        '{4'd6,  1'b1, 32'd10,        32'd3,         1'b0, 4'b0000, 32'd6,         1'b1, 4'b0010, 1'b0}, // R3
        '{4'd7,  1'b1, 32'd3,         32'd10,        1'b0, 4'b0010, 32'd7,         1'b1, 4'b0010, 1'b0}, // R3
        '{4'd8,  1'b1, 32'h0000_000F, 32'h0000_00F0, 1'b0, 4'b0001, 32'h0000_0000, 1'b0, 4'b0101, 1'b0}, // R4 R9
        '{4'd9,  1'b0, 32'd1,         32'd1,         1'b0, 4'b1100, 32'h0000_0000, 1'b0, 4'b1100, 1'b1}, // R5
        '{4'd10, 1'b1, 32'h8000_0000, 32'd1,         1'b0, 4'b0000, 32'h7FFF_FFFF, 1'b0, 4'b0011, 1'b0}, // R4 R8
        '{4'd11, 1'b1, 32'hFFFF_FFFF, 32'd1,         1'b0, 4'b0000, 32'h0000_0000, 1'b0, 4'b0110, 1'b0}, // R4 R7
        '{4'd12, 1'b1, 32'd0,         32'd0,         1'b1, 4'b0000, 32'h0000_0000, 1'b1, 4'b0110, 1'b0}, // R1 R6
        '{4'd13, 1'b0, 32'd0,         32'hDEAD_BEEF, 1'b0, 4'b1111, 32'hDEAD_BEEF, 1'b1, 4'b1111, 1'b0}, // R1 R10
        '{4'd14, 1'b1, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 4'b0011, 32'hFFFF_0000, 1'b1, 4'b1001, 1'b0}, // R1 R9
        '{4'd15, 1'b1, 32'd0,         32'd0,         1'b1, 4'b0000, 32'hFFFF_FFFF, 1'b1, 4'b1010, 1'b0}, // R1 R6
        '{4'd10, 1'b1, 32'd5,         32'd5,         1'b0, 4'b0000, 32'h0000_0000, 1'b0, 4'b0110, 1'b0}  // R7 R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  opcode = '0;
    logic        set_flags = 1'b0;
    logic [31:0] op_a = '0;
    logic        a_is_pc = 1'b0;
    logic [31:0] inst_addr = '0;
    logic        reg_shift = 1'b0;
    logic [31:0] op_b = '0;
    logic        shift_carry = 1'b0;
    logic [3:0]  flags_in = '0;
    logic        out_valid, reg_we, unsupported;
    logic [31:0] result;
    logic [3:0]  flags_out;
    int          total = 0;
    int          bad = 0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    alu_dp u_alu_dp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .set_flags(set_flags), .op_a(op_a), .a_is_pc(a_is_pc),
        .inst_addr(inst_addr), .reg_shift(reg_shift), .op_b(op_b),
        .shift_carry(shift_carry), .flags_in(flags_in),
        .out_valid(out_valid), .result(result), .reg_we(reg_we),
        .flags_out(flags_out), .unsupported(unsupported)
    );

    function automatic string req_of(input logic [3:0] op, input logic s);
        if (op[3:2] == 2'b10) return s ? "R4" : "R5";
        if (op >= 4'd5 && op <= 4'd7) return "R3";
        if (op >= 4'd2 && op <= 4'd4) return "R2";
        return s ? "R9" : "R10";
    endfunction

    task automatic check(input string tag, input logic [38:0] act, input logic [38:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; sample at the following falling edge.
    task automatic issue(input logic [3:0] op, input logic s, input logic [31:0] a,
                         input logic [31:0] b, input logic sc, input logic [3:0] fin,
                         input logic pc, input logic rs, input logic [31:0] ia);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; set_flags = s; op_a = a; op_b = b;
        shift_carry = sc; flags_in = fin; a_is_pc = pc; reg_shift = rs; inst_addr = ia;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset", {out_valid, result, reg_we, unsupported, 1'b0, flags_out[3:2]}, 39'd0);
        check("R12 reset flags", {35'd0, flags_out}, 39'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].s, VEC[i].a, VEC[i].b, VEC[i].sc, VEC[i].fin, 1'b0, 1'b0, 32'hFFFF_0000);
            check(req_of(VEC[i].op, VEC[i].s),
                  {out_valid, result, reg_we, flags_out, unsupported},
                  {1'b1, VEC[i].res, VEC[i].we, VEC[i].fl, VEC[i].un});
        end

        // R12: idle cycle gives no valid, write or unsupported
        @(negedge clk);
        check("R12 idle", {36'd0, out_valid, reg_we, unsupported}, 39'd0);

        // R11: PC operand with immediate shift, then register shift, then ignored address
        issue(4'd4, 1'b0, 32'h5555_5555, 32'd0, 1'b0, 4'b0000, 1'b1, 1'b0, 32'h0000_1000);
        check("R11 pc+8", {7'd0, result}, {7'd0, 32'h0000_1008});
        issue(4'd4, 1'b0, 32'h5555_5555, 32'd0, 1'b0, 4'b0000, 1'b1, 1'b1, 32'h0000_1000);
        check("R11 pc+12", {7'd0, result}, {7'd0, 32'h0000_100C});
        issue(4'd4, 1'b0, 32'h0000_0040, 32'd2, 1'b0, 4'b0000, 1'b0, 1'b1, 32'h0000_1000);
        check("R11 no pc", {7'd0, result}, {7'd0, 32'h0000_0042});

        // R12: reset mid-stream clears outputs
        @(negedge clk);
        in_valid = 1'b1; opcode = 4'd13; op_b = 32'hAAAA_AAAA; set_flags = 1'b1; flags_in = 4'b1111;
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R12 sync reset", {out_valid, result, reg_we, unsupported, 1'b0, flags_out[3:2]}, 39'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule